// File: doc/BRIEF.md
# Light Sensor Measurement Scheduler

This block sets the timing of conversions for a light sensing front end that has two channels: a main channel and a clear channel. Software programs it through a byte-wide register port. The registers hold an enable bit, an integration-time code, a repeat-rate code and a gain code. Once enabled, the block waits a fixed wake-up time. It then opens an integration window. When the window closes it captures the two 20-bit converter outputs into result registers and raises a data-ready flag. It starts the next window at the end of each measurement period.

All time is counted in ticks of 0.625 ms. The tick comes from a prescaler that divides the system clock by `TICK_DIV`. A measurement period lasts for the larger of the integration time and the repeat period. A write to the rate or gain register during a measurement abandons that conversion and starts a fresh one. A software reset bit returns every register to its reset value.

Top module: `light_meas_sched`

## Requirements
- R1: After reset, the registers read as follows: control (0x00) reads 0x00, rate (0x04) reads 0x20, gain (0x05) reads 0x01, status (0x07) reads 0x00 and the result bytes read 0x00. The outputs `integ_window`, `result_strobe` and `data_ready` are low.
- R2: The integration code sits in bits 6:4 of register 0x04. It selects 640, 320, 160, 80, 40 or 5 ticks for codes 0 to 5. Codes 6 and 7 behave as code 0.
- R3: The repeat code sits in bits 2:0 of register 0x04. It selects 40, 80, 160, 320, 800, 1600 or 3200 ticks for codes 0 to 6. Code 7 behaves as code 6.
- R4: Each period starts with `integ_window` high for the integration length. The window then stays low until the period ends. The period is the larger of the integration and repeat lengths. When the two lengths are equal, the window stays high across the period boundary.
- R5: A write that sets bit 1 of register 0x00 while the block is off holds the window low for 8 ticks before the first window opens. Writing the bit as 1 again while it is already on restarts nothing.
- R6: A write to register 0x04 or 0x05 while measuring restarts the period at once. The next capture comes one integration length after that write, and the abandoned window produces no capture.
- R7: At the end of every window, both inputs are captured in the same cycle, and `result_strobe` pulses for one cycle. The clear result sits little-endian at 0x0A..0x0C and the main result at 0x0D..0x0F. The top 4 bits of the third byte read 0. Result bytes change only at a capture.
- R8: A capture sets bit 3 of status register 0x07 and the `data_ready` output. A read of 0x07 with `rd_en` high clears both.
- R9: Writing bit 1 of register 0x00 as 0 stops measuring: the window goes low and no further captures occur.
- R10: Writing bit 4 of register 0x00 as 1 returns every register and the results to their R1 values and stops measuring. The bit itself always reads 0.
- R11: Writes to addresses other than 0x00, 0x04 and 0x05 change nothing. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Read strobe; clears data-ready when the address is 0x07 |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| adc_main | input | RES_W | Main channel converter output |
| adc_clear | input | RES_W | Clear channel converter output |
| integ_window | output | 1 | High while the converter integrates |
| result_strobe | output | 1 | One-cycle pulse when the results are captured |
| data_ready | output | 1 | A new result is waiting to be read |

## Verification
The bench predicts the exact cycle of every capture from the codes and the prescaler. It targets these cases:
- A window longer than the repeat period: a design that used the repeat period alone would capture too early.
- Equal lengths: a design that dropped the window for a cycle at the boundary would show it.
- The unused codes: a design that decoded them as zero length would run away.
- A rate or gain write part-way through a period: a design that kept counting would capture too early or from the abandoned window.

It also changes the converter inputs between captures, so results that are not held would be seen. It re-asserts enable while running, so a spurious restart would shift the capture times.

// File: rtl/light_meas_sched.sv
module light_meas_sched #(
  parameter int TICK_DIV   = 31250,
  parameter int WAKE_TICKS = 8,
  parameter int RES_W      = 20,
  parameter int CNT_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic [RES_W-1:0] adc_main,
  input  logic [RES_W-1:0] adc_clear,
  output logic             integ_window,
  output logic             result_strobe,
  output logic             data_ready
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int UNIT  = 5;  // shortest window in ticks
  localparam logic [7:0] A_CTRL = 8'h00, A_RATE = 8'h04, A_GAIN = 8'h05, A_STAT = 8'h07;
  localparam logic [7:0] A_CLR0 = 8'h0A, A_MAIN0 = 8'h0D;
  localparam logic [2:0] RST_INTEG = 3'd2, RST_REP = 3'd0, RST_GAIN = 3'd1;

  typedef enum logic [1:0] {S_OFF, S_WAKE, S_MEAS} state_t;

  state_t             state;
  logic               en_q, ready_q;
  logic [2:0]         integ_q, rep_q, gain_q;
  logic [PRE_W-1:0]   pre;
  logic [CNT_W-1:0]   cnt;
  logic [RES_W-1:0]   main_q, clr_q;
  logic [23:0]        main24, clr24;

  function automatic logic [CNT_W-1:0] integ_len(input logic [2:0] c);
    case (c)
      3'd1:    return CNT_W'(UNIT * 64);
      3'd2:    return CNT_W'(UNIT * 32);
      3'd3:    return CNT_W'(UNIT * 16);
      3'd4:    return CNT_W'(UNIT * 8);
      3'd5:    return CNT_W'(UNIT);
      default: return CNT_W'(UNIT * 128);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] rep_len(input logic [2:0] c);
    case (c)
      3'd0:    return CNT_W'(UNIT * 8);
      3'd1:    return CNT_W'(UNIT * 16);
      3'd2:    return CNT_W'(UNIT * 32);
      3'd3:    return CNT_W'(UNIT * 64);
      3'd4:    return CNT_W'(UNIT * 160);
      3'd5:    return CNT_W'(UNIT * 320);
      default: return CNT_W'(UNIT * 640);
    endcase
  endfunction

  logic [CNT_W-1:0] win_len, per_len;
  logic wr_ctrl, sw_rst, en_on, en_off, param_wr, tick, waking;
  logic unused_bits;

  assign win_len  = integ_len(integ_q);
  assign per_len  = (win_len > rep_len(rep_q)) ? win_len : rep_len(rep_q);
  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign sw_rst   = wr_ctrl && wr_data[4];
  assign en_on    = wr_ctrl && wr_data[1] && !en_q;
  assign en_off   = wr_ctrl && !wr_data[1];
  assign param_wr = wr_en && ((wr_addr == A_RATE) || (wr_addr == A_GAIN));
  assign tick     = (pre == PRE_W'(TICK_DIV - 1));
  assign waking   = (state == S_WAKE);
  assign unused_bits = ^{wr_data[7], wr_data[5], wr_data[3]};

  assign integ_window = (state == S_MEAS) && (cnt < win_len);
  assign data_ready   = ready_q;
  assign main24 = 24'(main_q);
  assign clr24  = 24'(clr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF; en_q <= 1'b0; ready_q <= 1'b0; result_strobe <= 1'b0;
      integ_q <= RST_INTEG; rep_q <= RST_REP; gain_q <= RST_GAIN;
      pre <= '0; cnt <= '0; main_q <= '0; clr_q <= '0;
    end else if (sw_rst) begin
      state <= S_OFF; en_q <= 1'b0; ready_q <= 1'b0; result_strobe <= 1'b0;
      integ_q <= RST_INTEG; rep_q <= RST_REP; gain_q <= RST_GAIN;
      pre <= '0; cnt <= '0; main_q <= '0; clr_q <= '0;
    end else begin
      result_strobe <= 1'b0;
      pre <= tick ? '0 : pre + 1'b1;
      if (wr_ctrl) en_q <= wr_data[1];
      if (wr_en && wr_addr == A_RATE) begin
        integ_q <= wr_data[6:4];
        rep_q   <= wr_data[2:0];
      end
      if (wr_en && wr_addr == A_GAIN) gain_q <= wr_data[2:0];
      if (rd_en && rd_addr == A_STAT) ready_q <= 1'b0;
      case (state)
        S_OFF: if (en_on) begin
          state <= S_WAKE; cnt <= '0; pre <= '0;
        end
        S_WAKE: begin
          if (en_off) state <= S_OFF;
          else if (tick) begin
            if (cnt == CNT_W'(WAKE_TICKS - 1)) begin
              state <= S_MEAS; cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (en_off) state <= S_OFF;
          else if (param_wr) begin
            cnt <= '0; pre <= '0;
          end else if (tick) begin
            if (cnt == win_len - 1'b1) begin
              main_q <= adc_main; clr_q <= adc_clear;
              result_strobe <= 1'b1; ready_q <= 1'b1;
            end
            cnt <= (cnt == per_len - 1'b1) ? '0 : cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:      rd_data = {6'b0, en_q, 1'b0};
      A_RATE:      rd_data = {1'b0, integ_q, 1'b0, rep_q};
      A_GAIN:      rd_data = {5'b0, gain_q};
      A_STAT:      rd_data = {4'b0, ready_q, 3'b0};
      A_CLR0:      rd_data = clr24[7:0];
      A_CLR0 + 1:  rd_data = clr24[15:8];
      A_CLR0 + 2:  rd_data = clr24[23:16];
      A_MAIN0:     rd_data = main24[7:0];
      A_MAIN0 + 1: rd_data = main24[15:8];
      A_MAIN0 + 2: rd_data = main24[23:16];
      default:     rd_data = 8'h00;
    endcase
  end

endmodule

module light_meas_sched_chk #(
  parameter int RES_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             waking,
  input logic             sw_rst,
  input logic             integ_window,
  input logic             result_strobe,
  input logic             data_ready,
  input logic [RES_W-1:0] main_q
);

  assert_window_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !integ_window);

  assert_no_capture_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_strobe |-> en);

  assert_quiet_during_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    waking |-> !integ_window);

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result_strobe |=> !result_strobe);

  assert_ready_on_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result_strobe |-> data_ready);

  assert_results_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!result_strobe && !$past(sw_rst)) |-> $stable(main_q));

endmodule

bind light_meas_sched light_meas_sched_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .waking(waking), .sw_rst(sw_rst),
  .integ_window(integ_window), .result_strobe(result_strobe),
  .data_ready(data_ready), .main_q(main_q)
);

// File: tb/tb_light_meas_sched.sv
module tb_light_meas_sched;
  localparam int D = 2;
  localparam int WAKE = 8 * D;
  localparam int LIMIT = 150000;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0, rd_data;
  logic [19:0] adc_main = 0, adc_clear = 0;
  logic integ_window, result_strobe, data_ready;

  int cyc = 0, checks = 0, fails = 0, last_edge = 0;
  int q[$];

  light_meas_sched #(.TICK_DIV(D)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .adc_main(adc_main), .adc_clear(adc_clear),
    .integ_window(integ_window), .result_strobe(result_strobe), .data_ready(data_ready)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: each capture must match the next predicted cycle
  always @(negedge clk) begin
    if (rst_n && result_strobe) begin
      int e;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R6/R9 unexpected capture actual=%0d expected=none", cyc);
      end else begin
        e = q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL R4 capture cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    last_edge = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd_clr();
    @(negedge clk);
    rd_en = 1; rd_addr = 8'h07;
    @(posedge clk);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input int exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // one enable run: returns start of first window
  task automatic enable_run(output int ms);
    wr(8'h00, 8'h02);
    ms = last_edge + WAKE;
  endtask

  initial begin
    int ms, w, g;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rchk("R1 ctrl", 8'h00, 8'h00);
    rchk("R1 rate", 8'h04, 8'h20);
    rchk("R1 gain", 8'h05, 8'h01);
    rchk("R1 status", 8'h07, 8'h00);
    rchk("R1 main lo", 8'h0D, 8'h00);
    rchk("R1 clear hi", 8'h0C, 8'h00);
    chk("R1 window", integ_window, 0);
    chk("R1 ready", data_ready, 0);

    // R2 default code 2 (160 ticks), R5 wake and re-enable, R9 stop
    enable_run(ms);
    q.push_back(ms + 160 * D);
    q.push_back(ms + 320 * D);
    wait_cyc(ms - 1); chk("R5 window low at end of wake", integ_window, 0);
    wait_cyc(ms);     chk("R5 window opens after wake", integ_window, 1);
    wait_cyc(ms + 60);
    wr(8'h00, 8'h02);  // R5 re-enable must not restart
    wait_cyc(ms + 320 * D + 2);
    chk("R5 R2 all captures seen", q.size(), 0);
    wr(8'h00, 8'h00);
    chk("R9 window low after disable", integ_window, 0);
    wait_cyc(cyc + 400);

    // R4 R7 R8 short window (code 5) with repeat code 0
    adc_main = 20'hABCDE; adc_clear = 20'h12345;
    wr(8'h04, 8'h50);
    enable_run(ms);
    q.push_back(ms + 5 * D);
    q.push_back(ms + 45 * D);
    q.push_back(ms + 85 * D);
    wait_cyc(ms + 5 * D - 1); chk("R4 window high in integration", integ_window, 1);
    wait_cyc(ms + 5 * D);     chk("R4 window low after integration", integ_window, 0);
    wait_cyc(ms + 5 * D + 1);
    rchk("R7 main byte0", 8'h0D, 8'hDE);
    rchk("R7 main byte1", 8'h0E, 8'hBC);
    rchk("R7 main byte2", 8'h0F, 8'h0A);
    rchk("R7 clear byte0", 8'h0A, 8'h45);
    rchk("R7 clear byte1", 8'h0B, 8'h23);
    rchk("R7 clear byte2", 8'h0C, 8'h01);
    chk("R8 ready output", data_ready, 1);
    rchk("R8 status bit3", 8'h07, 8'h08);
    rd_clr();
    chk("R8 ready cleared", data_ready, 0);
    rchk("R8 status cleared", 8'h07, 8'h00);
    adc_main = 20'hF0F0F; adc_clear = 20'h00777;
    wait_cyc(ms + 30 * D);
    rchk("R7 held between captures", 8'h0D, 8'hDE);
    wait_cyc(ms + 40 * D - 1); chk("R4 window low before period end", integ_window, 0);
    wait_cyc(ms + 40 * D);     chk("R4 next window opens", integ_window, 1);
    wait_cyc(ms + 45 * D + 1);
    rchk("R7 new main byte2", 8'h0F, 8'h0F);
    rchk("R7 new clear byte1", 8'h0B, 8'h07);
    wait_cyc(ms + 85 * D + 1);
    // R11 writes to other addresses are ignored
    wr(8'h0D, 8'hFF);
    wr(8'h07, 8'hFF);
    rchk("R11 result not writable", 8'h0D, 8'h0F);
    rchk("R11 status not writable", 8'h07, 8'h08);
    rchk("R11 unmapped reads zero", 8'h03, 8'h00);
    rchk("R11 rate unchanged", 8'h04, 8'h50);
    wr(8'h00, 8'h00);
    wait_cyc(cyc + 200);

    // R4 equal lengths (code 4, repeat 0): window stays high
    wr(8'h04, 8'h40);
    enable_run(ms);
    q.push_back(ms + 40 * D);
    q.push_back(ms + 80 * D);
    wait_cyc(ms + 40 * D); chk("R4 window continuous at boundary", integ_window, 1);
    wait_cyc(ms + 80 * D + 1);
    wr(8'h00, 8'h00);
    wait_cyc(cyc + 50);

    // R2 unused integration code 6 acts as 640 ticks
    wr(8'h04, 8'h60);
    enable_run(ms);
    q.push_back(ms + 640 * D);
    wait_cyc(ms + 640 * D + 1);
    chk("R2 code 6 capture", q.size(), 0);
    wr(8'h00, 8'h00);
    wait_cyc(cyc + 50);

    // R3 repeat code 1 (80 ticks)
    wr(8'h04, 8'h51);
    enable_run(ms);
    q.push_back(ms + 5 * D);
    q.push_back(ms + 85 * D);
    wait_cyc(ms + 85 * D + 1);
    chk("R3 code 1 period", q.size(), 0);
    wr(8'h00, 8'h00);
    wait_cyc(cyc + 50);

    // R3 unused repeat code 7 acts as 3200 ticks
    wr(8'h04, 8'h57);
    enable_run(ms);
    q.push_back(ms + 5 * D);
    q.push_back(ms + 3205 * D);
    wait_cyc(ms + 3205 * D + 1);
    chk("R3 code 7 period", q.size(), 0);
    wr(8'h00, 8'h00);
    wait_cyc(cyc + 50);

    // R6 restart on rate write, then on gain write
    wr(8'h04, 8'h50);
    enable_run(ms);
    q.push_back(ms + 5 * D);
    wait_cyc(ms + 20 * D);
    wr(8'h04, 8'h40);
    w = last_edge;
    chk("R6 window reopens on rate write", integ_window, 1);
    q.push_back(w + 40 * D);
    wait_cyc(w + 50 * D);
    wr(8'h05, 8'h04);
    g = last_edge;
    q.push_back(g + 40 * D);
    rchk("R6 gain stored", 8'h05, 8'h04);
    wait_cyc(g + 40 * D + 1);
    chk("R6 captures after restarts", q.size(), 0);
    wr(8'h00, 8'h00);
    wait_cyc(cyc + 50);

    // R10 software reset while measuring
    enable_run(ms);
    wait_cyc(ms + 10 * D);
    wr(8'h00, 8'h12);
    chk("R10 window low", integ_window, 0);
    rchk("R10 ctrl", 8'h00, 8'h00);
    rchk("R10 rate", 8'h04, 8'h20);
    rchk("R10 gain", 8'h05, 8'h01);
    rchk("R10 status", 8'h07, 8'h00);
    rchk("R10 results cleared", 8'h0E, 8'h00);
    chk("R10 ready", data_ready, 0);
    wait_cyc(cyc + 600);
    chk("R10 no pending captures", q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule